// File: doc/BRIEF.md
# Virtual Function Routing ID Allocator

This block works out where the virtual functions of one physical function sit in the 8-bit device/function number space. Its inputs are the parent function's own number, a start offset, a spacing (stride), the number of virtual functions provided, the number currently switched on, and a flag that says whether the alternative routing-ID interpretation is in use. With that flag set, the slot field no longer bounds the function number. From these inputs the block decides whether the layout is legal and reports the first and last virtual function numbers. All of these results are registered, so each one follows its inputs by one clock.

Two lookups read that registered layout. The forward lookup turns a zero-based virtual function index into a function number and a hit flag one clock later. The reverse lookup is a small state machine that maps an incoming function number back to an index by repeated subtraction of the stride. It has three states. RV_IDLE waits for a start pulse. RV_WALK subtracts one stride per clock while it searches. RV_REPORT holds the result and the done strobe for one clock. There are five transitions. IDLE→REPORT is the early reject: the layout is invalid, no function is enabled, or the number is below the first function. IDLE→WALK means the start was accepted and the number is a candidate. WALK→WALK is one subtraction step. WALK→REPORT is taken on a match or when the search is exhausted. REPORT→IDLE always follows.

Top module: `vf_rid_alloc`

## Requirements
- R1: When the layout is valid and at least one function is provided, `first_vf_fn` equals `pf_fn + vf_offset`.
- R2: In the same case, `last_vf_fn` equals the first number plus `vf_stride * (total_vfs - 1)`.
- R3: With `ari_en` low, the layout is invalid if bits 7:3 of the last number differ from bits 7:3 of `pf_fn`. With `ari_en` high, this slot test is not applied.
- R4: The layout is invalid whenever the exact (unwrapped) last number is 256 or more. This holds with `ari_en` high as well. An invalid layout reports 0 on both `first_vf_fn` and `last_vf_fn`.
- R5: A `total_vfs` of zero is always valid and reports 0 on both number outputs.
- R6: `cfg_valid`, `first_vf_fn` and `last_vf_fn` change exactly one clock edge after their inputs change, never earlier. After reset all three read 0.
- R7: One edge after `fwd_idx` is presented, `fwd_hit` is high if the layout is valid and the index is below the effective enabled count. In that case `fwd_fn` = first + index × stride. On a miss `fwd_fn` is 0.
- R8: The effective enabled count is `num_vfs_en` when it is at most `total_vfs`, and zero when it is larger.
- R9: The reverse lookup reports a hit with `rev_idx` = (fn − first) / stride when fn ≥ first, the difference is an exact multiple of the stride, and the quotient is below the effective enabled count. With a stride of zero, only fn = first hits, at index 0. Any other case is a miss with `rev_idx` 0.
- R10: `rev_done` is a single-cycle pulse. Count the edge that samples `rev_start` as edge 1. An early reject raises done after edge 1. A hit at index j raises done after edge j+2. A search that fails raises done no later than after edge enabled+1.
- R11: `rev_busy` is high from the edge that accepts a start through the done cycle. A `rev_start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_fn | input | 8 | Parent function device/function number |
| vf_offset | input | 16 | Offset from parent to first virtual function |
| vf_stride | input | 16 | Spacing between consecutive virtual functions |
| total_vfs | input | 8 | Number of virtual functions provided |
| num_vfs_en | input | 8 | Number of virtual functions currently switched on |
| ari_en | input | 1 | Slot field does not bound function numbers |
| cfg_valid | output | 1 | Registered layout-legal flag |
| first_vf_fn | output | 8 | First virtual function number (0 if none/invalid) |
| last_vf_fn | output | 8 | Last virtual function number (0 if none/invalid) |
| fwd_idx | input | 8 | Forward lookup index |
| fwd_fn | output | 8 | Forward lookup function number |
| fwd_hit | output | 1 | Forward lookup hit |
| rev_start | input | 1 | Start pulse for reverse lookup |
| rev_fn | input | 8 | Function number to map back |
| rev_busy | output | 1 | Reverse lookup in progress |
| rev_done | output | 1 | Reverse result strobe |
| rev_hit | output | 1 | Reverse lookup hit (qualified by done) |
| rev_idx | output | 8 | Reverse lookup index (qualified by done) |

## Verification
The layout outputs and the forward lookup are due one edge after their inputs. The bench drives on the falling edge and reads on the next falling edge, so exactly one rising edge lies in between. For the timing requirement it also reads right after a change, before any edge, to show the old values are still held. The reverse lookup's due edge depends on the index. The bench counts rising edges from the edge that samples the start, and compares that count with the number R10 gives for each case: early reject, a hit at a given index, and a failed search. The other layout inputs are held steady across each walk.

// File: rtl/vf_rid_pkg.sv
package vf_rid_pkg;

    typedef enum logic [1:0] {
        RV_IDLE,
        RV_WALK,
        RV_REPORT
    } rev_state_e;

endpackage

// File: rtl/vf_rid_cfg.sv
module vf_rid_cfg #(
    parameter int FN_W     = 8,
    parameter int OFS_W    = 16,
    parameter int CNT_W    = 8,
    parameter int SLOT_LSB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FN_W-1:0]  pf_fn,
    input  logic [OFS_W-1:0] vf_offset,
    input  logic [OFS_W-1:0] vf_stride,
    input  logic [CNT_W-1:0] total_vfs,
    input  logic [CNT_W-1:0] num_vfs_en,
    input  logic             ari_en,
    output logic             valid_q,
    output logic [FN_W-1:0]  first_q,
    output logic [FN_W-1:0]  last_q,
    output logic [OFS_W-1:0] stride_q,
    output logic [CNT_W-1:0] enabled_q
);
    localparam int WIDE_W  = OFS_W + CNT_W + FN_W + 1;
    localparam int FN_SPAN = 1 << FN_W;

    logic [WIDE_W-1:0] first_w;
    logic [WIDE_W-1:0] last_w;
    logic [CNT_W-1:0]  top_idx;
    logic              slot_ok;
    logic              range_ok;
    logic              valid_n;
    logic              has_vfs;

    always_comb begin
        top_idx  = (total_vfs == '0) ? '0 : total_vfs - CNT_W'(1);
        first_w  = WIDE_W'(pf_fn) + WIDE_W'(vf_offset);
        last_w   = first_w + WIDE_W'(vf_stride) * WIDE_W'(top_idx);
        range_ok = last_w < WIDE_W'(FN_SPAN);
        slot_ok  = ari_en || (last_w[FN_W-1:SLOT_LSB] == pf_fn[FN_W-1:SLOT_LSB]);
        valid_n  = (total_vfs == '0) || (range_ok && slot_ok);
        has_vfs  = valid_n && (total_vfs != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            first_q   <= '0;
            last_q    <= '0;
            stride_q  <= '0;
            enabled_q <= '0;
        end else begin
            valid_q   <= valid_n;
            first_q   <= has_vfs ? first_w[FN_W-1:0] : '0;
            last_q    <= has_vfs ? last_w[FN_W-1:0]  : '0;
            stride_q  <= vf_stride;
            enabled_q <= (num_vfs_en <= total_vfs) ? num_vfs_en : '0;
        end
    end
endmodule

// File: rtl/vf_rid_fwd.sv
module vf_rid_fwd #(
    parameter int FN_W  = 8,
    parameter int OFS_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic [FN_W-1:0]  first,
    input  logic [OFS_W-1:0] stride,
    input  logic [CNT_W-1:0] enabled,
    input  logic [CNT_W-1:0] idx,
    output logic [FN_W-1:0]  fn_q,
    output logic             hit_q
);
    localparam int PROD_W = OFS_W + CNT_W + 1;

    logic [PROD_W-1:0] place;
    logic              hit_n;

    always_comb begin
        place = PROD_W'(first) + PROD_W'(stride) * PROD_W'(idx);
        hit_n = cfg_ok && (idx < enabled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit_n;
            fn_q  <= hit_n ? place[FN_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/vf_rid_rev.sv
module vf_rid_rev
    import vf_rid_pkg::*;
#(
    parameter int FN_W  = 8,
    parameter int OFS_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic [FN_W-1:0]  first,
    input  logic [OFS_W-1:0] stride,
    input  logic [CNT_W-1:0] enabled,
    input  logic             start,
    input  logic [FN_W-1:0]  fn,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [CNT_W-1:0] idx
);
    rev_state_e       state_q, state_n;
    logic [FN_W-1:0]  rem_q;
    logic [CNT_W-1:0] idx_q;
    logic             hit_q;
    logic             reject;
    logic             match;
    logic             give_up;

    always_comb begin
        reject  = !cfg_ok || (fn < first) || (enabled == '0);
        match   = (rem_q == '0);
        give_up = !match && ((stride == '0) || (OFS_W'(rem_q) < stride) ||
                  ({1'b0, idx_q} + (CNT_W+1)'(1) >= {1'b0, enabled}));
        state_n = state_q;
        unique case (state_q)
            RV_IDLE:   if (start) state_n = reject ? RV_REPORT : RV_WALK;
            RV_WALK:   if (match || give_up) state_n = RV_REPORT;
            RV_REPORT: state_n = RV_IDLE;
            default:   state_n = RV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RV_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            idx_q <= '0;
            hit_q <= 1'b0;
        end else begin
            unique case (state_q)
                RV_IDLE: if (start) begin
                    rem_q <= fn - first;
                    idx_q <= '0;
                    hit_q <= 1'b0;
                end
                RV_WALK: begin
                    if (match) begin
                        hit_q <= 1'b1;
                    end else if (give_up) begin
                        hit_q <= 1'b0;
                        idx_q <= '0;
                    end else begin
                        rem_q <= rem_q - stride[FN_W-1:0];
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                RV_REPORT: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state_q != RV_IDLE);
        done = (state_q == RV_REPORT);
        hit  = done && hit_q;
        idx  = done ? idx_q : '0;
    end
endmodule

// File: rtl/vf_rid_alloc.sv
module vf_rid_alloc #(
    parameter int FN_W     = 8,
    parameter int OFS_W    = 16,
    parameter int CNT_W    = 8,
    parameter int SLOT_LSB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FN_W-1:0]  pf_fn,
    input  logic [OFS_W-1:0] vf_offset,
    input  logic [OFS_W-1:0] vf_stride,
    input  logic [CNT_W-1:0] total_vfs,
    input  logic [CNT_W-1:0] num_vfs_en,
    input  logic             ari_en,
    output logic             cfg_valid,
    output logic [FN_W-1:0]  first_vf_fn,
    output logic [FN_W-1:0]  last_vf_fn,
    input  logic [CNT_W-1:0] fwd_idx,
    output logic [FN_W-1:0]  fwd_fn,
    output logic             fwd_hit,
    input  logic             rev_start,
    input  logic [FN_W-1:0]  rev_fn,
    output logic             rev_busy,
    output logic             rev_done,
    output logic             rev_hit,
    output logic [CNT_W-1:0] rev_idx
);
    logic [OFS_W-1:0] stride_q;
    logic [CNT_W-1:0] enabled_q;

    vf_rid_cfg #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .SLOT_LSB(SLOT_LSB)) cfg_i (
        .clk(clk), .rst_n(rst_n), .pf_fn(pf_fn), .vf_offset(vf_offset),
        .vf_stride(vf_stride), .total_vfs(total_vfs), .num_vfs_en(num_vfs_en),
        .ari_en(ari_en), .valid_q(cfg_valid), .first_q(first_vf_fn),
        .last_q(last_vf_fn), .stride_q(stride_q), .enabled_q(enabled_q)
    );

    vf_rid_fwd #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) fwd_i (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_valid), .first(first_vf_fn),
        .stride(stride_q), .enabled(enabled_q), .idx(fwd_idx),
        .fn_q(fwd_fn), .hit_q(fwd_hit)
    );

    vf_rid_rev #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) rev_i (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_valid), .first(first_vf_fn),
        .stride(stride_q), .enabled(enabled_q), .start(rev_start), .fn(rev_fn),
        .busy(rev_busy), .done(rev_done), .hit(rev_hit), .idx(rev_idx)
    );
endmodule

// File: rtl/vf_rid_alloc_chk.sv
module vf_rid_alloc_chk #(
    parameter int FN_W  = 8,
    parameter int OFS_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FN_W-1:0]  pf_fn,
    input logic [OFS_W-1:0] vf_offset,
    input logic [CNT_W-1:0] total_vfs,
    input logic             cfg_valid,
    input logic [FN_W-1:0]  first_vf_fn,
    input logic [FN_W-1:0]  last_vf_fn,
    input logic             rev_start,
    input logic             rev_busy,
    input logic             rev_done
);
    localparam int SUM_W = OFS_W + 2;
    logic             past_ok;
    logic [SUM_W-1:0] sum_w;

    assign sum_w = SUM_W'(pf_fn) + SUM_W'(vf_offset);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r5_zero_total: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(total_vfs == '0)) |-> (cfg_valid && first_vf_fn == '0 && last_vf_fn == '0));

    a_r4_first_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(total_vfs != '0 && sum_w >= SUM_W'(1 << FN_W))) |-> !cfg_valid);

    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (first_vf_fn <= last_vf_fn));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rev_done |=> !rev_done);

    a_r11_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_start && !rev_busy) |=> rev_busy);

    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rev_done |-> rev_busy);
endmodule

bind vf_rid_alloc vf_rid_alloc_chk #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pf_fn(pf_fn), .vf_offset(vf_offset),
    .total_vfs(total_vfs), .cfg_valid(cfg_valid), .first_vf_fn(first_vf_fn),
    .last_vf_fn(last_vf_fn), .rev_start(rev_start), .rev_busy(rev_busy),
    .rev_done(rev_done)
);

// File: tb/vf_rid_alloc_tb_top.sv
module vf_rid_alloc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pf_fn = '0;
    logic [15:0] vf_offset = '0;
    logic [15:0] vf_stride = '0;
    logic [7:0]  total_vfs = '0;
    logic [7:0]  num_vfs_en = '0;
    logic        ari_en = 1'b0;
    logic        cfg_valid;
    logic [7:0]  first_vf_fn, last_vf_fn;
    logic [7:0]  fwd_idx = '0;
    logic [7:0]  fwd_fn;
    logic        fwd_hit;
    logic        rev_start = 1'b0;
    logic [7:0]  rev_fn = '0;
    logic        rev_busy, rev_done, rev_hit;
    logic [7:0]  rev_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vf_rid_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .pf_fn(pf_fn), .vf_offset(vf_offset),
        .vf_stride(vf_stride), .total_vfs(total_vfs), .num_vfs_en(num_vfs_en),
        .ari_en(ari_en), .cfg_valid(cfg_valid), .first_vf_fn(first_vf_fn),
        .last_vf_fn(last_vf_fn), .fwd_idx(fwd_idx), .fwd_fn(fwd_fn),
        .fwd_hit(fwd_hit), .rev_start(rev_start), .rev_fn(rev_fn),
        .rev_busy(rev_busy), .rev_done(rev_done), .rev_hit(rev_hit),
        .rev_idx(rev_idx)
    );

    // {pf, offset, stride, total, ari, exp_valid, exp_first, exp_last}
    localparam int NVEC = 10;
    localparam logic [65:0] VEC [NVEC] = '{
        {8'h08, 16'd1,    16'd1,    8'd4, 1'b0, 1'b1, 8'd9,   8'd12},  // R1 R2 same slot
        {8'h08, 16'd1,    16'd1,    8'd8, 1'b0, 1'b0, 8'd0,   8'd0},   // R3 slot crossed
        {8'h08, 16'd1,    16'd1,    8'd8, 1'b1, 1'b1, 8'd9,   8'd16},  // R3 ari ignores slot
        {8'h00, 16'h80,   16'h10,   8'd8, 1'b1, 1'b1, 8'd128, 8'd240}, // R2
        {8'h00, 16'h80,   16'h10,   8'd9, 1'b1, 1'b0, 8'd0,   8'd0},   // R4 last = 256
        {8'h10, 16'd0,    16'd0,    8'd0, 1'b0, 1'b1, 8'd0,   8'd0},   // R5
        {8'h20, 16'd2,    16'd2,    8'd3, 1'b0, 1'b1, 8'd34,  8'd38},  // R1
        {8'hF0, 16'h20,   16'd1,    8'd1, 1'b1, 1'b0, 8'd0,   8'd0},   // R4 first >= 256
        {8'h01, 16'd3,    16'd0,    8'd5, 1'b0, 1'b1, 8'd4,   8'd4},   // R2 stride zero
        {8'h00, 16'hFF,   16'd1,    8'd1, 1'b1, 1'b1, 8'd255, 8'd255}  // R4 edge 255
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [65:0] v);
        @(negedge clk);
        {pf_fn, vf_offset, vf_stride, total_vfs, ari_en} = v[65:17];
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fwd(input logic [7:0] i, input logic exp_hit, input logic [7:0] exp_fn, input string req);
        @(negedge clk);
        fwd_idx = i;
        @(negedge clk);
        chk({req, " fwd_hit"}, 32'(fwd_hit), 32'(exp_hit));
        chk({req, " fwd_fn"}, 32'(fwd_fn), 32'(exp_fn));
    endtask

    task automatic rev(input logic [7:0] f, input logic exp_hit, input logic [7:0] exp_idx,
                       input int exp_cyc, input string req);
        int cyc;
        logic seen;
        @(negedge clk);
        rev_fn = f;
        rev_start = 1'b1;
        cyc = 0;
        seen = 1'b0;
        while (!seen && cyc < 300) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            rev_start = 1'b0;
            if (rev_done) seen = 1'b1;
        end
        chk({req, " R10 done edges"}, 32'(cyc), 32'(exp_cyc));
        chk({req, " rev_hit"}, 32'(rev_hit), 32'(exp_hit));
        chk({req, " rev_idx"}, 32'(rev_idx), 32'(exp_idx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 reset valid", 32'(cfg_valid), 0);
        chk("R6 reset first", 32'(first_vf_fn), 0);
        chk("R11 reset busy", 32'(rev_busy), 0);
        chk("R7 reset fwd_hit", 32'(fwd_hit), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            set_cfg(VEC[k]);
            chk($sformatf("R1-vec%0d valid", k), 32'(cfg_valid), 32'(VEC[k][16]));
            chk($sformatf("R1 vec%0d first", k), 32'(first_vf_fn), 32'(VEC[k][15:8]));
            chk($sformatf("R2 vec%0d last", k), 32'(last_vf_fn), 32'(VEC[k][7:0]));
        end

        // forward lookups: first 128, stride 16, total 8, 5 enabled
        num_vfs_en = 8'd5;
        set_cfg(VEC[3]);
        fwd(8'd0, 1'b1, 8'd128, "R7 idx0");
        fwd(8'd4, 1'b1, 8'd192, "R7 idx4");
        fwd(8'd5, 1'b0, 8'd0,   "R7 idx beyond enabled");

        // reverse lookups
        rev(8'hA0, 1'b1, 8'd2, 4, "R9 hit idx2");
        rev(8'h88, 1'b0, 8'd0, 2, "R9 not multiple");
        rev(8'h70, 1'b0, 8'd0, 1, "R9 below first");
        rev(8'hD0, 1'b0, 8'd0, 6, "R9 index not enabled");
        rev(8'h80, 1'b1, 8'd0, 2, "R9 hit idx0");

        // R11: start while busy is ignored
        @(negedge clk);
        rev_fn = 8'hA0;
        rev_start = 1'b1;
        @(negedge clk);
        chk("R11 busy after accept", 32'(rev_busy), 1);
        rev_fn = 8'h80;
        @(negedge clk);
        rev_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 done for first request", 32'(rev_done), 1);
        chk("R11 idx of first request", 32'(rev_idx), 2);
        @(negedge clk);
        chk("R11 no restart done", 32'(rev_done), 0);
        chk("R11 no restart busy", 32'(rev_busy), 0);

        // R8: enabled count above total
        num_vfs_en = 8'd9;
        set_cfg(VEC[3]);
        fwd(8'd0, 1'b0, 8'd0, "R8 fwd");
        rev(8'h80, 1'b0, 8'd0, 1, "R8 rev");

        // R6: change applies only after one edge
        num_vfs_en = 8'd5;
        set_cfg(VEC[3]);
        total_vfs = 8'd9;
        #1;
        chk("R6 valid held before edge", 32'(cfg_valid), 1);
        @(negedge clk);
        chk("R6 valid after edge", 32'(cfg_valid), 0);

        // stride zero
        set_cfg(VEC[8]);
        fwd(8'd3, 1'b1, 8'd4, "R7 stride zero");
        rev(8'd4, 1'b1, 8'd0, 2, "R9 stride zero hit");
        rev(8'd5, 1'b0, 8'd0, 2, "R9 stride zero miss");
        rev(8'd3, 1'b0, 8'd0, 1, "R10 early reject");

        // invalid layout rejects everything
        set_cfg(VEC[1]);
        fwd(8'd0, 1'b0, 8'd0, "R7 invalid layout");
        rev(8'd9, 1'b0, 8'd0, 1, "R10 invalid layout");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule